// File: doc/BRIEF.md
# Scanline Doubling Video Upscaler

This block turns a 256x240 picture, delivered one line at a time by a tile-based picture generator, into a 640x480 raster with VGA timing. Everything runs on one system clock. The source side writes at a quarter of that clock, and the display side advances one pixel slot every second clock. Each source pixel therefore covers two display slots, which gives a 512-pixel image. The image is centred, with 64 black columns on each side. Each source line is shown on two consecutive display lines. The second of the two is either a copy of the first or solid black, selected by `dbl_mode`.

Line storage is a pair of banks used in ping-pong fashion. The generator fills one bank while the display reads the other. A line-start strobe flips a write-select bit. That bit passes through a two-stage synchroniser on the display step, and the display takes the opposite bank at the start of each even active line. Sizes and timing intervals are parameters. Every interval must be at least one unit long, and 2*SRC_W must not exceed H_ACT.

Both the horizontal and the vertical timing come from one segment state machine, instantiated twice. Its states are ACTIVE, FRONT, SYNC and BACK. It moves ACTIVE to FRONT at the end of the visible span, FRONT to SYNC at the end of the front porch, SYNC to BACK at the end of the pulse, and BACK to ACTIVE at the end of the period. The pixel stage sorts every display slot into one of four kinds: BLANK (outside the visible area), PAD (side column), DARK (odd line in black-line mode) or IMAGE. Only IMAGE passes buffer data.

Top module: `scan_doubler`

## Requirements
- R1: A display line is 800 slots of two clocks each. `vga_hsync_n` is low for 96 slots, beginning 656 slots after the start of the visible span.
- R2: A frame is 525 lines. `vga_vsync_n` is low for 2 whole lines, beginning after 480 visible lines and 10 porch lines.
- R3: In visible lines, display columns 0..63 and 576..639 carry 0 (black).
- R4: Source pixel x of source line y appears unchanged in display columns 64+2x and 65+2x of display line 2y.
- R5: With `dbl_mode`=0, display line 2y+1 repeats display line 2y column for column.
- R6: With `dbl_mode`=1, every odd display line (2y+1) is 0 in all columns.
- R7: `vga_rgb` is 0 in every slot outside the 640x480 visible area, including both sync intervals.
- R8: Each `src_line_start` pulse toggles the write bank. The display line pair for source line y shows the line written between the two most recent pulses before that pair began. Writes never land in the bank being displayed.
- R9: While `rst_n` is low, `vga_rgb` is 0 and both syncs are high (inactive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_we | input | 1 | Source pixel write qualifier, at most one per four clocks |
| src_x | input | $clog2(SRC_W) | Source pixel column |
| src_pix | input | PIX_W | Source pixel colour word |
| src_line_start | input | 1 | One-clock pulse that begins a new source line |
| dbl_mode | input | 1 | 0: repeat each line; 1: black second line |
| vga_rgb | output | PIX_W | Output colour word, 0 when blanked |
| vga_hsync_n | output | 1 | Horizontal sync, active low |
| vga_vsync_n | output | 1 | Vertical sync, active low |

## Verification
The bank-separation property assumes that the generator pulses `src_line_start` once per display line pair, in the blanking part of the odd line before the pair, and finishes writing the next line before the following pulse. It also assumes that `dbl_mode` changes only during vertical blanking. The bench schedules every pulse at a fixed column of the horizontal blanking, measured from the observed vertical sync edge. It writes sixteen pixels at one per four clocks, which ends well before the next pulse. It changes the mode only in the blank lines between frames. Three frames carry different pixel data, so stale bank contents show up as a mismatch.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {SEG_ACTIVE, SEG_FRONT, SEG_SYNC, SEG_BACK} seg_t;
    typedef enum logic [1:0] {PX_BLANK, PX_PAD, PX_IMAGE, PX_DARK} px_kind_t;
endpackage

// File: rtl/scan_seg_fsm.sv
module scan_seg_fsm
    import scan_pkg::*;
#(
    parameter int ACT  = 640,
    parameter int FP   = 16,
    parameter int SYNC = 96,
    parameter int BP   = 48,
    localparam int TOT = ACT + FP + SYNC + BP,
    localparam int CW  = $clog2(TOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output seg_t          seg,
    output logic          last
);
    seg_t          state_q, state_d;
    logic [CW-1:0] cnt_q;

    // next-state selection: each segment ends at a fixed position
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEG_ACTIVE: if (cnt_q == CW'(ACT - 1))             state_d = SEG_FRONT;
            SEG_FRONT:  if (cnt_q == CW'(ACT + FP - 1))        state_d = SEG_SYNC;
            SEG_SYNC:   if (cnt_q == CW'(ACT + FP + SYNC - 1)) state_d = SEG_BACK;
            SEG_BACK:   if (cnt_q == CW'(TOT - 1))             state_d = SEG_ACTIVE;
            default:                                           state_d = SEG_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEG_ACTIVE;
            cnt_q   <= '0;
        end else if (step) begin
            state_q <= state_d;
            cnt_q   <= last ? '0 : cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CW'(TOT - 1));
    assign cnt  = cnt_q;
    assign seg  = state_q;
endmodule

// File: rtl/scan_linebuf.sv
module scan_linebuf #(
    parameter int PIX_W = 12,
    parameter int SRC_W = 256,
    localparam int XW   = $clog2(SRC_W)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wsel,
    input  logic [XW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic             rsel,
    input  logic [XW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);
    logic [PIX_W-1:0] bank_q [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [PIX_W-1:0] mem [SRC_W];

        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(b)) && (int'(waddr) < SRC_W))
                mem[waddr] <= wdata;
        end

        assign bank_q[b] = mem[raddr];
    end

    assign rdata = bank_q[rsel];
endmodule

// File: rtl/scan_swap.sv
module scan_swap (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic line_start,
    input  logic pair_start,
    output logic wr_sel,
    output logic rd_sel
);
    logic sync1_q, sync2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_sel <= 1'b0;
        end else if (line_start) begin
            wr_sel <= ~wr_sel;
        end
    end

    // select bit crosses into the display step through two stages
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            rd_sel  <= 1'b1;
        end else if (step) begin
            sync1_q <= wr_sel;
            sync2_q <= sync1_q;
            if (pair_start)
                rd_sel <= ~sync2_q;
        end
    end
endmodule

// File: rtl/scan_pixout.sv
module scan_pixout
    import scan_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int SRC_W = 256,
    parameter int H_ACT = 640,
    parameter int HCW   = 10,
    localparam int PAD  = (H_ACT - 2 * SRC_W) / 2,
    localparam int XW   = $clog2(SRC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [HCW-1:0]   h_cnt,
    input  seg_t             h_seg,
    input  seg_t             v_seg,
    input  logic             v_odd,
    input  logic             dbl_mode,
    input  logic [PIX_W-1:0] rd_data,
    output logic [XW-1:0]    rd_addr,
    output logic [PIX_W-1:0] rgb,
    output logic             hsync_n,
    output logic             vsync_n
);
    px_kind_t         kind;
    logic [HCW-1:0]   offs;
    logic [PIX_W-1:0] rgb_d;

    assign offs    = h_cnt - HCW'(PAD);
    assign rd_addr = offs[XW:1];

    always_comb begin
        if (h_seg != SEG_ACTIVE || v_seg != SEG_ACTIVE)
            kind = PX_BLANK;
        else if (h_cnt < HCW'(PAD) || offs >= HCW'(2 * SRC_W))
            kind = PX_PAD;
        else if (dbl_mode && v_odd)
            kind = PX_DARK;
        else
            kind = PX_IMAGE;
    end

    always_comb begin
        unique case (kind)
            PX_IMAGE:                  rgb_d = rd_data;
            PX_BLANK, PX_PAD, PX_DARK: rgb_d = '0;
            default:                   rgb_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rgb     <= '0;
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
        end else if (step) begin
            rgb     <= rgb_d;
            hsync_n <= (h_seg != SEG_SYNC);
            vsync_n <= (v_seg != SEG_SYNC);
        end
    end
endmodule

// File: rtl/scan_doubler.sv
module scan_doubler
    import scan_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int SRC_W  = 256,
    parameter int SRC_H  = 240,
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    localparam int XW    = $clog2(SRC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_we,
    input  logic [XW-1:0]    src_x,
    input  logic [PIX_W-1:0] src_pix,
    input  logic             src_line_start,
    input  logic             dbl_mode,
    output logic [PIX_W-1:0] vga_rgb,
    output logic             vga_hsync_n,
    output logic             vga_vsync_n
);
    localparam int V_ACT = 2 * SRC_H;
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HCW   = $clog2(H_TOT);
    localparam int VCW   = $clog2(V_TOT);

    logic             step_q;
    logic [HCW-1:0]   h_cnt;
    logic [VCW-1:0]   v_cnt, v_next;
    seg_t             h_seg, v_seg;
    logic             h_last, v_last, pair_start;
    logic             wr_sel, rd_sel, disp_act;
    logic [XW-1:0]    rd_addr;
    logic [PIX_W-1:0] rd_data;

    // display slot advances on every second clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= 1'b0;
        else        step_q <= ~step_q;
    end

    scan_seg_fsm #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_hseg (
        .clk(clk), .rst_n(rst_n), .step(step_q),
        .cnt(h_cnt), .seg(h_seg), .last(h_last)
    );

    scan_seg_fsm #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_vseg (
        .clk(clk), .rst_n(rst_n), .step(step_q && h_last),
        .cnt(v_cnt), .seg(v_seg), .last(v_last)
    );

    assign v_next     = v_last ? '0 : v_cnt + 1'b1;
    assign pair_start = h_last && (int'(v_next) < V_ACT) && !v_next[0];
    assign disp_act   = (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);

    scan_swap u_swap (
        .clk(clk), .rst_n(rst_n), .step(step_q),
        .line_start(src_line_start), .pair_start(pair_start),
        .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    scan_linebuf #(.PIX_W(PIX_W), .SRC_W(SRC_W)) u_buf (
        .clk(clk), .we(src_we), .wsel(wr_sel), .waddr(src_x), .wdata(src_pix),
        .rsel(rd_sel), .raddr(rd_addr), .rdata(rd_data)
    );

    scan_pixout #(.PIX_W(PIX_W), .SRC_W(SRC_W), .H_ACT(H_ACT), .HCW(HCW)) u_pix (
        .clk(clk), .rst_n(rst_n), .step(step_q),
        .h_cnt(h_cnt), .h_seg(h_seg), .v_seg(v_seg), .v_odd(v_cnt[0]),
        .dbl_mode(dbl_mode), .rd_data(rd_data), .rd_addr(rd_addr),
        .rgb(vga_rgb), .hsync_n(vga_hsync_n), .vsync_n(vga_vsync_n)
    );
endmodule

// File: rtl/scan_doubler_chk.sv
module scan_doubler_chk #(
    parameter int PIX_W  = 12,
    parameter int H_SYNC = 96,
    parameter int V_SYNC = 2,
    parameter int H_TOT  = 800
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync_n,
    input logic             vsync_n,
    input logic [PIX_W-1:0] rgb,
    input logic             src_we,
    input logic             wr_sel,
    input logic             rd_sel,
    input logic             disp_act
);
    int unsigned hs_low_q, vs_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_low_q <= 0;
            vs_low_q <= 0;
        end else begin
            hs_low_q <= hsync_n ? 0 : hs_low_q + 1;
            vs_low_q <= vsync_n ? 0 : vs_low_q + 1;
        end
    end

    // R1
    hsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> hs_low_q == 2 * H_SYNC);

    // R2
    vsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_n) |-> vs_low_q == 2 * V_SYNC * H_TOT);

    // R7
    sync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_n || !vsync_n) |-> rgb == '0);

    // R8
    bank_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_we && disp_act) |-> wr_sel != rd_sel);
endmodule

bind scan_doubler scan_doubler_chk #(
    .PIX_W(PIX_W), .H_SYNC(H_SYNC), .V_SYNC(V_SYNC), .H_TOT(H_TOT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hsync_n(vga_hsync_n), .vsync_n(vga_vsync_n),
    .rgb(vga_rgb), .src_we(src_we), .wr_sel(wr_sel), .rd_sel(rd_sel),
    .disp_act(disp_act)
);

// File: tb/sim_scan_doubler.sv
module sim_scan_doubler;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W  = 12;
    localparam int SRC_W  = 16;
    localparam int SRC_H  = 4;
    localparam int H_ACT  = 40;
    localparam int H_FP   = 2;
    localparam int H_SYNC = 6;
    localparam int H_BP   = 4;
    localparam int V_FP   = 1;
    localparam int V_SYNC = 2;
    localparam int V_BP   = 3;
    localparam int XW     = $clog2(SRC_W);
    localparam int V_ACT  = 2 * SRC_H;
    localparam int H_TOT  = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT  = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int PAD    = (H_ACT - 2 * SRC_W) / 2;
    localparam int STRB_COL = 44;
    localparam int NV = 17;
    // {display line, display column}, in display order
    localparam logic [9:0] VEC [NV] = '{
        {4'd0, 6'd0},  {4'd0, 6'd3},  {4'd0, 6'd4},  {4'd0, 6'd5},
        {4'd0, 6'd6},  {4'd1, 6'd4},  {4'd1, 6'd20}, {4'd2, 6'd10},
        {4'd2, 6'd11}, {4'd3, 6'd35}, {4'd3, 6'd36}, {4'd4, 6'd39},
        {4'd5, 6'd17}, {4'd6, 6'd21}, {4'd7, 6'd34}, {4'd7, 6'd42},
        {4'd8, 6'd0}
    };
    localparam bit FRAME_MODE [3] = '{1'b0, 1'b1, 1'b0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             src_we = 1'b0;
    logic [XW-1:0]    src_x = '0;
    logic [PIX_W-1:0] src_pix = '0;
    logic             src_line_start = 1'b0;
    logic             dbl_mode = 1'b0;
    logic [PIX_W-1:0] vga_rgb;
    logic             vga_hsync_n, vga_vsync_n;

    int cyc = 0;
    int c0 = 0;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scan_doubler #(
        .PIX_W(PIX_W), .SRC_W(SRC_W), .SRC_H(SRC_H), .H_ACT(H_ACT),
        .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .src_we(src_we), .src_x(src_x),
        .src_pix(src_pix), .src_line_start(src_line_start), .dbl_mode(dbl_mode),
        .vga_rgb(vga_rgb), .vga_hsync_n(vga_hsync_n), .vga_vsync_n(vga_vsync_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [PIX_W-1:0] pat(int f, int k, int x);
        return {4'(k + 1 + 4 * f), 4'(x), 4'hA};
    endfunction

    function automatic logic [PIX_W-1:0] expect_px(int f, bit m, int ln, int c);
        if (ln >= V_ACT || c >= H_ACT) return '0;
        if (c < PAD || c >= PAD + 2 * SRC_W) return '0;
        if (m && (ln % 2 == 1)) return '0;
        return pat(f, ln / 2, (c - PAD) / 2);
    endfunction

    function automatic string tag_of(bit m, int ln, int c);
        if (ln >= V_ACT || c >= H_ACT) return "R7 blank";
        if (c < PAD || c >= PAD + 2 * SRC_W) return "R3 pad";
        if (ln % 2 == 1) return m ? "R6 dark line" : "R5 repeat";
        return "R4 R8 image";
    endfunction

    // first slot of display line 0 of frame f, counted from the vsync edge
    function automatic int base_slot(int f);
        return (V_TOT - (V_ACT + V_FP)) * H_TOT + f * V_TOT * H_TOT;
    endfunction

    task automatic wait_slot(input int n);
        while (cyc < c0 + 2 * n) @(negedge clk);
    endtask

    task automatic drive_frames();
        for (int f = 0; f < 3; f++) begin
            wait_slot(base_slot(f) - 120);
            dbl_mode = FRAME_MODE[f];
            for (int k = -1; k < SRC_H; k++) begin
                wait_slot(base_slot(f) + (2 * k - 1) * H_TOT + STRB_COL);
                src_line_start = 1'b1;
                @(negedge clk);
                src_line_start = 1'b0;
                if (k + 1 < SRC_H) begin
                    for (int x = 0; x < SRC_W; x++) begin
                        src_we  = 1'b1;
                        src_x   = XW'(x);
                        src_pix = pat(f, k + 1, x);
                        @(negedge clk);
                        src_we = 1'b0;
                        repeat (3) @(negedge clk);
                    end
                end
            end
        end
    endtask

    task automatic check_frames();
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < NV; i++) begin
                int ln = int'(VEC[i][9:6]);
                int c  = int'(VEC[i][5:0]);
                wait_slot(base_slot(f) + ln * H_TOT + c);
                chk($sformatf("%s frame=%0d line=%0d col=%0d", tag_of(FRAME_MODE[f], ln, c), f, ln, c),
                    32'(vga_rgb), 32'(expect_px(f, FRAME_MODE[f], ln, c)));
            end
        end
    endtask

    initial begin
        int t_fall, t_rise;
        bit prev;
        // R9: reset state
        repeat (5) @(negedge clk);
        chk("R9 reset rgb", 32'(vga_rgb), 32'd0);
        chk("R9 reset hsync_n", 32'(vga_hsync_n), 32'd1);
        chk("R9 reset vsync_n", 32'(vga_vsync_n), 32'd1);
        rst_n = 1'b1;

        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (prev && !vga_vsync_n) break;
            prev = vga_vsync_n;
        end
        c0 = cyc;

        fork
            drive_frames();
            check_frames();
        join

        // R1: hsync width and line period
        prev = vga_hsync_n;
        forever begin @(negedge clk); if (prev && !vga_hsync_n) break; prev = vga_hsync_n; end
        t_fall = cyc;
        while (!vga_hsync_n) @(negedge clk);
        t_rise = cyc;
        chk("R1 hsync low clocks", 32'(t_rise - t_fall), 32'(2 * H_SYNC));
        while (vga_hsync_n) @(negedge clk);
        chk("R1 line period clocks", 32'(cyc - t_fall), 32'(2 * H_TOT));

        // R2: vsync width and frame period
        prev = vga_vsync_n;
        forever begin @(negedge clk); if (prev && !vga_vsync_n) break; prev = vga_vsync_n; end
        t_fall = cyc;
        while (!vga_vsync_n) @(negedge clk);
        t_rise = cyc;
        chk("R2 vsync low clocks", 32'(t_rise - t_fall), 32'(2 * V_SYNC * H_TOT));
        while (vga_vsync_n) @(negedge clk);
        chk("R2 frame period clocks", 32'(cyc - t_fall), 32'(2 * V_TOT * H_TOT));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule